// File: doc/BRIEF.md
# Debug Cold-Plug Reset Extender

This block controls the order in which reset is released after the external reset pin goes away. While the pin is held, it keeps the system and the CPU in reset and selects the slow clock for the core, system and flash clock trees. After the pin is released and the clock source reports ready, the system leaves reset on a system-clock edge.

The CPU can be kept in reset after that point. The block samples the level of the serial-debug clock pin when the synchronized external reset deasserts. A low level means that a debugger is attached and wants control. In that case the CPU stays in reset while the rest of the chip runs, so the debugger can erase or program memory before any code executes. A status bit reads 1 while the hold is active, and the debugger releases the CPU by writing 1 to that bit. A high level at release lets the CPU leave reset together with the system.

A power-on reset restarts the whole sequence, and so does a new assertion of the external reset. Both input pins pass through synchronizer chains whose depth is a parameter.

Top module: `dbg_rst_extender`

## Requirements
- R1: While the synchronized external reset is asserted, sys_rst_o, cpu_rst_o and slow_clk_sel_o are all 1 and ext_status_o is 0.
- R2: If dbg_clk_i is low when the synchronized external reset deasserts, sys_rst_o is released, cpu_rst_o stays 1 and ext_status_o reads 1.
- R3: If dbg_clk_i is high when the synchronized external reset deasserts, cpu_rst_o falls in the same cycle as sys_rst_o and ext_status_o reads 0.
- R4: A write (wr_en_i=1) with wr_bit_i=1 during an active extension releases cpu_rst_o and clears ext_status_o on the next clock edge. Outside of an asserted system reset, a falling cpu_rst_o happens only after such a write.
- R5: A write with wr_bit_i=0 has no effect on cpu_rst_o or ext_status_o.
- R6: A write with wr_bit_i=1 has no effect while no extension is active or while sys_rst_o is still 1.
- R7: sys_rst_o stays 1 after the external reset is released until clk_ready_i has been seen high, and it falls only on an edge where clk_ready_i was 1.
- R8: Asserting ext_rst_n_i again puts both resets back into the asserted state. The next release takes a new sample of the debug pin.
- R9: One cycle of por_i=1 sets sys_rst_o, cpu_rst_o and slow_clk_sel_o to 1 and ext_status_o to 0.
- R10: Changes on dbg_clk_i after the sampling edge do not affect the extension.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the slow clock during reset) |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| ext_rst_n_i | input | 1 | External reset pin, active low, asynchronous |
| dbg_clk_i | input | 1 | Level of the serial-debug clock pin, asynchronous |
| clk_ready_i | input | 1 | Clock source stable indication |
| wr_en_i | input | 1 | Write strobe for the extension status bit |
| wr_bit_i | input | 1 | Value written to the extension status bit |
| sys_rst_o | output | 1 | System reset, active high |
| cpu_rst_o | output | 1 | CPU reset, active high |
| slow_clk_sel_o | output | 1 | Forces the core, system and flash clocks onto the slow clock |
| ext_status_o | output | 1 | Reads 1 while the CPU reset is extended |

## Verification
The bench builds the block with SYNC_STAGES=3 instead of the default 2. With the deeper chain, the checks cover a release latency that the default does not give. They also show that a debug pin toggled a few cycles after release is already outside the sampling window. Randomized pin levels, clock-ready delays and write values are repeated over many reset cycles. This covers extended and non-extended releases, ignored writes during the reset-held phase, and a power-on reset applied in the middle of an extension.

// File: rtl/dbgrst_pkg.sv
package dbgrst_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_WAIT = 2'd1,
        ST_RUN  = 2'd2
    } rel_state_e;

    typedef struct packed {
        logic sys_rst;
        logic slow_sel;
        logic in_hold;
        logic cap_v;
        logic cap_ext;
    } rel_ctl_t;

    function automatic logic clr_hit(input logic wr, input logic bit_v, input logic sys_up);
        return wr & bit_v & sys_up;
    endfunction

endpackage

// File: rtl/dbgrst_sync.sv
module dbgrst_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgrst_seq.sv
module dbgrst_seq
    import dbgrst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_rel,
    input  logic     dbg_lvl,
    input  logic     clk_ready,
    output rel_ctl_t ctl
);
    rel_state_e st, st_nx;

    always_comb begin
        st_nx = st;
        case (st)
            ST_HOLD: if (ext_rel) st_nx = ST_WAIT;
            ST_WAIT: begin
                if (!ext_rel)      st_nx = ST_HOLD;
                else if (clk_ready) st_nx = ST_RUN;
            end
            ST_RUN:  if (!ext_rel) st_nx = ST_HOLD;
            default: st_nx = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_HOLD;
        else     st <= st_nx;
    end

    always_comb begin
        ctl.sys_rst  = (st != ST_RUN);
        ctl.slow_sel = (st == ST_HOLD);
        ctl.in_hold  = (st == ST_HOLD);
        ctl.cap_v    = (st == ST_HOLD) && ext_rel;
        ctl.cap_ext  = ~dbg_lvl;
    end
endmodule

// File: rtl/dbgrst_flag.sv
module dbgrst_flag
    import dbgrst_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  rel_ctl_t ctl,
    input  logic     clr_req,
    output logic     ext
);
    always_ff @(posedge clk) begin
        if (rst)              ext <= 1'b0;
        else if (ctl.in_hold) ext <= ctl.cap_v ? ctl.cap_ext : 1'b0;
        else if (clr_req)     ext <= 1'b0;
    end
endmodule

// File: rtl/dbg_rst_extender.sv
module dbg_rst_extender
    import dbgrst_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_i,
    input  logic ext_rst_n_i,
    input  logic dbg_clk_i,
    input  logic clk_ready_i,
    input  logic wr_en_i,
    input  logic wr_bit_i,
    output logic sys_rst_o,
    output logic cpu_rst_o,
    output logic slow_clk_sel_o,
    output logic ext_status_o
);
    logic     ext_rel;
    logic     dbg_lvl;
    logic     ext_q;
    logic     clr_req;
    rel_ctl_t ctl;

    dbgrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ext_sync (
        .clk(clk), .rst(por_i), .d(ext_rst_n_i), .q(ext_rel)
    );

    dbgrst_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_dbg_sync (
        .clk(clk), .rst(por_i), .d(dbg_clk_i), .q(dbg_lvl)
    );

    dbgrst_seq u_seq (
        .clk(clk), .rst(por_i), .ext_rel(ext_rel), .dbg_lvl(dbg_lvl),
        .clk_ready(clk_ready_i), .ctl(ctl)
    );

    assign clr_req = clr_hit(wr_en_i, wr_bit_i, ~ctl.sys_rst);

    dbgrst_flag u_flag (
        .clk(clk), .rst(por_i), .ctl(ctl), .clr_req(clr_req), .ext(ext_q)
    );

    assign sys_rst_o      = ctl.sys_rst;
    assign cpu_rst_o      = ctl.sys_rst | ext_q;
    assign slow_clk_sel_o = ctl.slow_sel;
    assign ext_status_o   = ext_q & ~ctl.sys_rst;
endmodule

// File: rtl/dbgrst_chk.sv
module dbgrst_chk (
    input logic clk,
    input logic por_i,
    input logic clk_ready_i,
    input logic wr_en_i,
    input logic wr_bit_i,
    input logic sys_rst_o,
    input logic cpu_rst_o,
    input logic slow_clk_sel_o,
    input logic ext_status_o
);
    p_por_state_r9: assert property (@(posedge clk)
        por_i |=> (sys_rst_o && cpu_rst_o && slow_clk_sel_o && !ext_status_o));

    p_slow_held_r1: assert property (@(posedge clk) disable iff (por_i)
        slow_clk_sel_o |-> (sys_rst_o && cpu_rst_o && !ext_status_o));

    p_cpu_after_sys_r2: assert property (@(posedge clk) disable iff (por_i)
        sys_rst_o |-> cpu_rst_o);

    p_status_ext_r4: assert property (@(posedge clk) disable iff (por_i)
        ext_status_o |-> (cpu_rst_o && !sys_rst_o));

    p_release_by_write_r4: assert property (@(posedge clk) disable iff (por_i)
        ($fell(cpu_rst_o) && !$fell(sys_rst_o)) |-> $past(wr_en_i && wr_bit_i));

    p_no_write_hold_r5: assert property (@(posedge clk) disable iff (por_i)
        (!sys_rst_o && cpu_rst_o && !(wr_en_i && wr_bit_i)) |=> cpu_rst_o);

    p_ready_gate_r7: assert property (@(posedge clk) disable iff (por_i)
        $fell(sys_rst_o) |-> $past(clk_ready_i));
endmodule

bind dbg_rst_extender dbgrst_chk u_chk (.*);

// File: tb/sim_dbg_rst_extender.sv
`timescale 1ns/1ps
module sim_dbg_rst_extender;
    localparam int STG = 3;

    logic clk = 1'b0;
    logic por_i, ext_rst_n_i, dbg_clk_i, clk_ready_i, wr_en_i, wr_bit_i;
    logic sys_rst_o, cpu_rst_o, slow_clk_sel_o, ext_status_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dbg_rst_extender #(.SYNC_STAGES(STG)) u0 (
        .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i), .dbg_clk_i(dbg_clk_i),
        .clk_ready_i(clk_ready_i), .wr_en_i(wr_en_i), .wr_bit_i(wr_bit_i),
        .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o),
        .slow_clk_sel_o(slow_clk_sel_o), .ext_status_o(ext_status_o)
    );

    function automatic logic exp_extend(input logic pin);
        return !pin;
    endfunction

    function automatic logic exp_after_wr(input logic ext, input logic en, input logic b);
        return (en && b) ? 1'b0 : ext;
    endfunction

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic b);
        wr_en_i = 1'b1; wr_bit_i = b;
        @(negedge clk);
        wr_en_i = 1'b0; wr_bit_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic pin, ext, b, rdy_late;
        void'($urandom(32'h5eed));
        por_i = 1'b1; ext_rst_n_i = 1'b0; dbg_clk_i = 1'b1; clk_ready_i = 1'b0;
        wr_en_i = 1'b0; wr_bit_i = 1'b0;
        cyc(3);
        chk("R9", "sys_rst", sys_rst_o, 1'b1);
        chk("R9", "cpu_rst", cpu_rst_o, 1'b1);
        chk("R9", "status", ext_status_o, 1'b0);
        por_i = 1'b0;

        for (int it = 0; it < 60; it++) begin
            ext_rst_n_i = 1'b0;
            clk_ready_i = $urandom_range(0, 1);
            pin = (it == 0) ? 1'b0 : (it == 1) ? 1'b1 : logic'($urandom_range(0, 1));
            dbg_clk_i = pin;
            cyc(STG + 4);
            chk("R1", "sys_rst held", sys_rst_o, 1'b1);
            chk("R1", "cpu_rst held", cpu_rst_o, 1'b1);
            chk("R1", "slow clock sel", slow_clk_sel_o, 1'b1);
            chk("R8", "status cleared in hold", ext_status_o, 1'b0);

            rdy_late = $urandom_range(0, 1);
            clk_ready_i = rdy_late ? 1'b0 : 1'b1;
            ext_rst_n_i = 1'b1;
            cyc(STG + 4);
            chk("R1", "slow sel off after release", slow_clk_sel_o, 1'b0);
            if (rdy_late) begin
                wr(1'b1);   // R6: write while system reset asserted is ignored
                cyc($urandom_range(2, 20));
                chk("R7", "sys_rst waits ready", sys_rst_o, 1'b1);
                chk("R6", "status while sys in reset", ext_status_o, 1'b0);
                dbg_clk_i = ~pin;  // R10: late pin change
                clk_ready_i = 1'b1;
                cyc(2);
            end
            ext = exp_extend(pin);
            chk("R7", "sys_rst released", sys_rst_o, 1'b0);
            chk(ext ? "R2" : "R3", "cpu_rst after release", cpu_rst_o, ext);
            chk(ext ? "R2" : "R3", "status after release", ext_status_o, ext);
            dbg_clk_i = $urandom_range(0, 1);
            cyc(STG + 2);
            chk("R10", "pin change ignored", cpu_rst_o, ext);

            for (int k = 0; k < 5; k++) begin
                b = (it == 0 && k == 0) ? 1'b0 : logic'($urandom_range(0, 1));
                wr(b);
                ext = exp_after_wr(ext, 1'b1, b);
                chk(b ? (ext ? "R6" : "R4") : "R5", "cpu_rst after write", cpu_rst_o, ext);
                chk(b ? "R4" : "R5", "status after write", ext_status_o, ext);
                cyc($urandom_range(0, 3));
            end
        end

        ext_rst_n_i = 1'b0; dbg_clk_i = 1'b0;
        cyc(STG + 4);
        ext_rst_n_i = 1'b1; clk_ready_i = 1'b1;
        cyc(STG + 6);
        chk("R8", "re-sampled extension", ext_status_o, 1'b1);
        por_i = 1'b1;
        cyc(1);
        chk("R9", "por clears status", ext_status_o, 1'b0);
        chk("R9", "por asserts sys_rst", sys_rst_o, 1'b1);
        chk("R9", "por asserts cpu_rst", cpu_rst_o, 1'b1);
        por_i = 1'b0;
        cyc(2);

        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule